// File: doc/BRIEF.md
# VLIW Molecule Atom Dispatcher

This block sits between the fetch stage of a statically scheduled VLIW core and its five execution units: two integer units, a floating-point unit, a load/store unit and a branch unit. Each cycle it may take in one long instruction word (a molecule) that holds either two or four 32-bit sub-instructions (atoms). It sends every atom of that molecule to the unit named by the molecule's header, and all of them issue together in one cycle. No dependency check and no port arbitration take place. The header alone decides the routing, because the scheduler that built the molecule has already settled the hazards.

A molecule is accepted only when every unit it actually uses is ready. Otherwise the whole word waits on the input handshake, and a partial issue never happens. Slots that hold a no-operation atom use no unit, so they do not wait on that unit. A header naming a routing pattern that does not exist is consumed, nothing is issued for it, and a one-cycle error pulse follows.

Top module: `mol_dispatch`

## Requirements
- R1: After reset, and before any molecule is accepted, `iss_valid` is all zero, every lane of `iss_atom` is zero and `fmt_err` is low.
- R2: Slot 0 occupies `mol_data[31:0]`, slot k occupies `mol_data[32k+31:32k]`. Bit 0 of slot 0 selects the size: 0 means a short molecule that uses only slots 0 and 1, so `mol_data[127:64]` has no effect on any output; 1 means a long molecule that uses slots 0 to 3. Bits [3:1] of slot 0 hold the routing code. The whole slot word, header bits included, is forwarded.
- R3: Short routing codes map slots (0,1) to units as follows: code 0 gives (INT0, INT1), code 1 gives (INT0, MEM), code 2 gives (FPU, BR), code 3 gives (MEM, BR). Unit lanes are INT0=0, INT1=1, FPU=2, MEM=3, BR=4.
- R4: Long routing codes map slots (0,1,2,3) to units as follows: code 0 gives (INT0, INT1, MEM, BR), code 1 gives (INT0, FPU, MEM, BR), code 2 gives (INT0, INT1, FPU, MEM), code 3 gives (MEM, INT0, INT1, BR), code 4 gives (FPU, INT0, MEM, BR).
- R5: An atom whose bits [31:26] are zero is a no-operation. It raises no `iss_valid`, and the readiness of its mapped unit does not affect acceptance.
- R6: A molecule is accepted at a rising edge where `mol_valid` and `mol_ready` are both high. Right after that edge, every non-NOP atom appears on the `iss_atom` lane of its unit with `iss_valid` high, all in the same cycle and for that one cycle only. Lanes without a valid read zero.
- R7: For a legal molecule, `mol_ready` is low whenever any unit targeted by a non-NOP atom has `unit_ready` low. While it is low, nothing issues.
- R8: A molecule whose routing code is not listed for its size (short 4 to 7, long 5 to 7) sees `mol_ready` high, is consumed without any issue, and raises `fmt_err` for exactly the one cycle after its acceptance.
- R9: Molecules accepted on consecutive edges issue in consecutive cycles, each with its own routing.
- R10: With `mol_valid` low, nothing issues and `fmt_err` stays low, whatever `mol_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mol_valid | input | 1 | Molecule presented |
| mol_data | input | 128 | Molecule, four 32-bit slots, slot 0 in the low bits |
| mol_ready | output | 1 | Molecule can be consumed this cycle |
| unit_ready | input | 5 | Per-unit ready: INT0, INT1, FPU, MEM, BR at bits 0 to 4 |
| iss_valid | output | 5 | Per-unit issue strobe, same lane order |
| iss_atom | output | 160 | Per-unit atom, lane u at bits [32u+31:32u] |
| fmt_err | output | 1 | Pulse after an illegal routing code was consumed |

## Verification
`mol_ready` is a combinational function of the presented molecule and the unit readiness, so it is checked two nanoseconds after the inputs change, still inside the same cycle. Issue strobes, lane contents and the error pulse pass through exactly one register. They are checked at the falling edge after the accepting rising edge, and checked again one cycle later to confirm they lasted a single cycle. In the back-to-back scenario the next molecule is driven at the same falling edge where the previous one's outputs are sampled. This keeps each result tied to its own accepting edge.

// File: rtl/mol_dispatch_pkg.sv
package mol_dispatch_pkg;
   localparam int NUM_UNITS = 5;
   localparam int UNIT_W    = 3;

   typedef enum logic [UNIT_W-1:0] {
      U_INT0 = 3'd0,
      U_INT1 = 3'd1,
      U_FPU  = 3'd2,
      U_MEM  = 3'd3,
      U_BR   = 3'd4
   } unit_e;
endpackage

// File: rtl/mol_fmt_decode.sv
module mol_fmt_decode
   import mol_dispatch_pkg::*;
#(
   parameter int SLOTS = 4,
   parameter int FMT_W = 3
) (
   input  logic                          is_long,
   input  logic [FMT_W-1:0]              fmt,
   output logic                          legal,
   output logic [SLOTS-1:0]              slot_live,
   output logic [SLOTS-1:0][UNIT_W-1:0]  slot_unit
);
   localparam int SHORT_SLOTS = SLOTS / 2;

   if (SLOTS != 4) begin : g_bad_slots
      $error("mol_fmt_decode: routing table is defined for four slots");
   end
   if (FMT_W < 3) begin : g_bad_fmt
      $error("mol_fmt_decode: routing code needs at least three bits");
   end

   always_comb begin
      slot_live = is_long ? {SLOTS{1'b1}} : {{(SLOTS-SHORT_SLOTS){1'b0}}, {SHORT_SLOTS{1'b1}}};
   end

   always_comb begin
      legal     = 1'b1;
      slot_unit = '0;
      if (is_long) begin
         case (fmt)
            FMT_W'(0): slot_unit = {U_BR,  U_MEM,  U_INT1, U_INT0};
            FMT_W'(1): slot_unit = {U_BR,  U_MEM,  U_FPU,  U_INT0};
            FMT_W'(2): slot_unit = {U_MEM, U_FPU,  U_INT1, U_INT0};
            FMT_W'(3): slot_unit = {U_BR,  U_INT1, U_INT0, U_MEM};
            FMT_W'(4): slot_unit = {U_BR,  U_MEM,  U_INT0, U_FPU};
            default:   legal     = 1'b0;
         endcase
      end else begin
         case (fmt)
            FMT_W'(0): slot_unit = {U_INT0, U_INT0, U_INT1, U_INT0};
            FMT_W'(1): slot_unit = {U_INT0, U_INT0, U_MEM,  U_INT0};
            FMT_W'(2): slot_unit = {U_INT0, U_INT0, U_BR,   U_FPU};
            FMT_W'(3): slot_unit = {U_INT0, U_INT0, U_BR,   U_MEM};
            default:   legal     = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/mol_route.sv
module mol_route
   import mol_dispatch_pkg::*;
#(
   parameter int SLOTS  = 4,
   parameter int ATOM_W = 32,
   parameter int UNITS  = NUM_UNITS
) (
   input  logic [SLOTS-1:0][ATOM_W-1:0]  atoms,
   input  logic [SLOTS-1:0]              slot_act,
   input  logic [SLOTS-1:0][UNIT_W-1:0]  slot_unit,
   output logic [UNITS-1:0]              unit_hit,
   output logic [UNITS-1:0][ATOM_W-1:0]  unit_atom
);
   if (UNITS > (1 << UNIT_W)) begin : g_bad_units
      $error("mol_route: unit count exceeds unit index width");
   end

   for (genvar u = 0; u < UNITS; u++) begin : g_unit
      always_comb begin
         unit_hit[u]  = 1'b0;
         unit_atom[u] = '0;
         for (int s = 0; s < SLOTS; s++) begin
            if (slot_act[s] && (slot_unit[s] == UNIT_W'(u))) begin
               unit_hit[u]  = 1'b1;
               unit_atom[u] = unit_atom[u] | atoms[s];
            end
         end
      end
   end
endmodule

// File: rtl/mol_dispatch.sv
module mol_dispatch
   import mol_dispatch_pkg::*;
#(
   parameter int ATOM_W = 32,
   parameter int SLOTS  = 4,
   parameter int OP_W   = 6,
   parameter int NOP_OP = 0,
   parameter int FMT_W  = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        mol_valid,
   input  logic [SLOTS*ATOM_W-1:0]     mol_data,
   output logic                        mol_ready,
   input  logic [NUM_UNITS-1:0]        unit_ready,
   output logic [NUM_UNITS-1:0]        iss_valid,
   output logic [NUM_UNITS*ATOM_W-1:0] iss_atom,
   output logic                        fmt_err
);
   localparam int HDR_W = FMT_W + 1;

   if (ATOM_W < HDR_W + OP_W) begin : g_bad_atom
      $error("mol_dispatch: atom too narrow for header and opcode");
   end
   if (NOP_OP >= (1 << OP_W)) begin : g_bad_nop
      $error("mol_dispatch: NOP opcode does not fit the opcode field");
   end

   logic [SLOTS-1:0][ATOM_W-1:0]     atoms;
   logic [SLOTS-1:0]                 slot_live;
   logic [SLOTS-1:0]                 slot_nop;
   logic [SLOTS-1:0][UNIT_W-1:0]     slot_unit;
   logic                             legal;
   logic [NUM_UNITS-1:0]             need;
   logic [NUM_UNITS-1:0][ATOM_W-1:0] routed;
   logic                             fire;

   assign atoms = mol_data;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign slot_nop[s] = (atoms[s][ATOM_W-1 -: OP_W] == OP_W'(NOP_OP));
   end

   mol_fmt_decode #(.SLOTS(SLOTS), .FMT_W(FMT_W)) u_dec (
      .is_long   (atoms[0][0]),
      .fmt       (atoms[0][FMT_W:1]),
      .legal     (legal),
      .slot_live (slot_live),
      .slot_unit (slot_unit)
   );

   mol_route #(.SLOTS(SLOTS), .ATOM_W(ATOM_W), .UNITS(NUM_UNITS)) u_route (
      .atoms     (atoms),
      .slot_act  (slot_live & ~slot_nop),
      .slot_unit (slot_unit),
      .unit_hit  (need),
      .unit_atom (routed)
   );

   assign mol_ready = !legal || ((need & ~unit_ready) == '0);
   assign fire      = mol_valid && mol_ready && legal;

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            iss_valid[u]                  <= 1'b0;
            iss_atom[u*ATOM_W +: ATOM_W]  <= '0;
         end else begin
            iss_valid[u]                  <= fire && need[u];
            iss_atom[u*ATOM_W +: ATOM_W]  <= (fire && need[u]) ? routed[u] : '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fmt_err <= 1'b0;
      else        fmt_err <= mol_valid && !legal;
   end
endmodule

// File: rtl/mol_dispatch_chk.sv
module mol_dispatch_chk #(
   parameter int NU    = 5,
   parameter int MOL_W = 128
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mol_valid,
   input logic [MOL_W-1:0] mol_data,
   input logic             mol_ready,
   input logic [NU-1:0]    unit_ready,
   input logic [NU-1:0]    iss_valid,
   input logic             fmt_err
);
   // R6, R10: an issue only follows an accepting handshake
   p_issue_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid != '0) |-> $past(mol_valid && mol_ready));

   // R7: every unit that receives an atom was ready at acceptance
   p_issue_unit_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid & ~$past(unit_ready)) == '0);

   // R8: an error pulse never comes with an issue
   p_err_no_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_err |-> (iss_valid == '0));

   // R10: the error pulse follows a presented molecule
   p_err_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_err |-> $past(mol_valid));

   // R2: a short molecule drives at most two units
   p_short_two_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mol_valid && mol_ready && !mol_data[0]) |-> ($countones(iss_valid) <= 2));
endmodule

bind mol_dispatch mol_dispatch_chk #(.NU(5), .MOL_W(128)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mol_valid  (mol_valid),
   .mol_data   (mol_data),
   .mol_ready  (mol_ready),
   .unit_ready (unit_ready),
   .iss_valid  (iss_valid),
   .fmt_err    (fmt_err)
);

// File: tb/mol_dispatch_bench.sv
module mol_dispatch_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mol_valid = 1'b0;
   logic [127:0] mol_data = '0;
   logic         mol_ready;
   logic [4:0]   unit_ready = '0;
   logic [4:0]   iss_valid;
   logic [159:0] iss_atom;
   logic         fmt_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   mol_dispatch u_mol_dispatch (
      .clk(clk), .rst_n(rst_n), .mol_valid(mol_valid), .mol_data(mol_data),
      .mol_ready(mol_ready), .unit_ready(unit_ready), .iss_valid(iss_valid),
      .iss_atom(iss_atom), .fmt_err(fmt_err)
   );

   task automatic check(bit ok, string req, string what, logic [159:0] act, logic [159:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // unit index from the routing tables of R3 and R4, -1 when unused/illegal
   function automatic int unit_of(bit lng, int fmt, int s);
      if (!lng) begin
         if (s > 1) return -1;
         case (fmt)
            0: return (s == 0) ? 0 : 1;
            1: return (s == 0) ? 0 : 3;
            2: return (s == 0) ? 2 : 4;
            3: return (s == 0) ? 3 : 4;
            default: return -1;
         endcase
      end
      case (fmt)
         0: case (s) 0: return 0; 1: return 1; 2: return 3; default: return 4; endcase
         1: case (s) 0: return 0; 1: return 2; 2: return 3; default: return 4; endcase
         2: case (s) 0: return 0; 1: return 1; 2: return 2; default: return 3; endcase
         3: case (s) 0: return 3; 1: return 0; 2: return 1; default: return 4; endcase
         4: case (s) 0: return 2; 1: return 0; 2: return 3; default: return 4; endcase
         default: return -1;
      endcase
   endfunction

   function automatic logic [127:0] mk(bit lng, int fmt, logic [3:0] nop, int seed);
      logic [127:0] m;
      for (int s = 0; s < 4; s++) begin
         logic [31:0] w;
         w[31:26] = nop[s] ? 6'd0 : 6'(8 + s + seed);
         w[25:0]  = 26'(seed * 977 + s * 131 + 5);
         if (s == 0) w[3:0] = {3'(fmt), lng};
         m[s*32 +: 32] = w;
      end
      return m;
   endfunction

   task automatic model(logic [127:0] m, logic [4:0] r, output bit rdy, output bit acc,
                        output logic [4:0] v, output logic [159:0] a, output bit e);
      bit lng = m[0];
      int fmt = int'(m[3:1]);
      bit legal = lng ? (fmt <= 4) : (fmt <= 3);
      logic [4:0] need = '0;
      logic [159:0] lanes = '0;
      for (int s = 0; s < (lng ? 4 : 2); s++) begin
         int u = unit_of(lng, fmt, s);
         if (legal && u >= 0 && m[s*32+26 +: 6] != 6'd0) begin
            need[u] = 1'b1;
            lanes[u*32 +: 32] = m[s*32 +: 32];
         end
      end
      rdy = !legal || ((need & ~r) == 5'd0);
      acc = legal && rdy;
      v   = acc ? need : 5'd0;
      a   = acc ? lanes : '0;
      e   = !legal;
   endtask

   // present one molecule, check ready, outputs and one-cycle duration
   task automatic send(logic [127:0] m, logic [4:0] r, string req);
      bit rdy, acc, e;
      logic [4:0] v;
      logic [159:0] a;
      model(m, r, rdy, acc, v, a, e);
      @(negedge clk);
      mol_valid = 1'b1; mol_data = m; unit_ready = r;
      #2;
      check(mol_ready == rdy, req, "mol_ready", 160'(mol_ready), 160'(rdy));
      @(negedge clk);
      mol_valid = 1'b0;
      check(iss_valid == v, req, "iss_valid", 160'(iss_valid), 160'(v));
      check(iss_atom == a, req, "iss_atom", iss_atom, a);
      check(fmt_err == e, req, "fmt_err", 160'(fmt_err), 160'(e));
      @(negedge clk);
      check(iss_valid == 5'd0 && fmt_err == 1'b0, "R6", "single-cycle pulse",
            160'({iss_valid, fmt_err}), 160'(0));
   endtask

   task automatic t_reset();
      check(iss_valid == 5'd0, "R1", "iss_valid after reset", 160'(iss_valid), 160'(0));
      check(iss_atom == '0, "R1", "iss_atom after reset", iss_atom, 160'(0));
      check(fmt_err == 1'b0, "R1", "fmt_err after reset", 160'(fmt_err), 160'(0));
   endtask

   task automatic t_short();
      for (int f = 0; f < 4; f++) send(mk(1'b0, f, 4'b0000, 3 + f), 5'h1f, "R3");
      // R2: upper half holds non-NOP atoms aimed at busy units; no effect
      send(mk(1'b0, 0, 4'b0000, 11), 5'b00011, "R2");
      send(mk(1'b0, 0, 4'b0000, 11) ^ {64'hdead_beef_0bad_f00d, 64'd0}, 5'b00011, "R2");
   endtask

   task automatic t_long();
      for (int f = 0; f < 5; f++) send(mk(1'b1, f, 4'b0000, 20 + f), 5'h1f, "R4");
   endtask

   task automatic t_nop();
      // long code 0: NOPs in slots 0 and 2 (INT0, MEM), those units busy
      send(mk(1'b1, 0, 4'b0101, 30), 5'b10110, "R5");
      send(mk(1'b0, 2, 4'b0010, 31), 5'b00100, "R5");
   endtask

   task automatic t_stall();
      // long code 1 needs MEM; MEM busy -> whole molecule waits
      send(mk(1'b1, 1, 4'b0000, 40), 5'b10111, "R7");
      send(mk(1'b1, 1, 4'b0000, 40), 5'b11111, "R7");
      send(mk(1'b0, 3, 4'b0000, 41), 5'b01111, "R7");
   endtask

   task automatic t_illegal();
      send(mk(1'b0, 5, 4'b0000, 50), 5'd0, "R8");
      send(mk(1'b1, 7, 4'b0000, 51), 5'h1f, "R8");
      send(mk(1'b0, 4, 4'b0000, 52), 5'h1f, "R8");
   endtask

   task automatic t_b2b();
      logic [127:0] ma = mk(1'b1, 2, 4'b0000, 60);
      logic [127:0] mb = mk(1'b0, 1, 4'b0000, 61);
      bit rdy, acc, e;
      logic [4:0] va, vb;
      logic [159:0] aa, ab;
      model(ma, 5'h1f, rdy, acc, va, aa, e);
      model(mb, 5'h1f, rdy, acc, vb, ab, e);
      @(negedge clk);
      mol_valid = 1'b1; mol_data = ma; unit_ready = 5'h1f;
      @(negedge clk);
      mol_data = mb;
      check(iss_valid == va && iss_atom == aa, "R9", "first of pair",
            {iss_atom[154:0], iss_valid}, {aa[154:0], va});
      @(negedge clk);
      mol_valid = 1'b0;
      check(iss_valid == vb && iss_atom == ab, "R9", "second of pair",
            {iss_atom[154:0], iss_valid}, {ab[154:0], vb});
      @(negedge clk);
   endtask

   task automatic t_idle();
      @(negedge clk);
      mol_valid = 1'b0; mol_data = mk(1'b1, 7, 4'b0000, 70); unit_ready = 5'h1f;
      @(negedge clk);
      mol_data = mk(1'b1, 0, 4'b0000, 71);
      check(fmt_err == 1'b0, "R10", "no error while idle", 160'(fmt_err), 160'(0));
      @(negedge clk);
      check(iss_valid == 5'd0, "R10", "no issue while idle", 160'(iss_valid), 160'(0));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_short();
      t_long();
      t_nop();
      t_stall();
      t_illegal();
      t_b2b();
      t_idle();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule